// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block keeps a small, fully associative set of recently used page-table entries so that a virtual address can be turned into a physical address without walking the page tables. Each slot holds a virtual page number, the address-space (process) identifier that owns it, a physical frame number and five state bits. A lookup presents a 32-bit virtual address and the current process identifier. In the same cycle the block reports hit or miss, the physical address and the state bits. The 12-bit page offset is passed through unchanged.

When a lookup misses, an external page-table walker installs the entry through the fill inputs. The fill first reuses a slot that already holds the same page for the same process. If there is no such slot, it takes the lowest-numbered empty slot. If the buffer is full, a round-robin pointer chooses the victim.

Two invalidation controls are provided. One clears every slot. The other clears only the slots owned by a given process. When process tagging is switched off, the identifier takes no part in matching, and software must clear the whole buffer whenever it switches process.

Top module: `tlb_tagged`

## Requirements
- R1: After reset every slot is empty, so every lookup misses.
- R2: With tagging on, a lookup hits only on a valid slot whose page number (address bits 31:12) and process identifier both equal the request. On a hit, lk_paddr is {frame, lk_vaddr[11:0]}, and the result appears in the same cycle as the request.
- R3: On a miss, lk_hit is 0 and both lk_paddr and lk_flags are all zero.
- R4: Two slots with the same page number but different process identifiers coexist, and each returns its own frame.
- R5: With tag_en low, the process identifier is ignored both when matching lookups and when checking a fill for a duplicate.
- R6: A fill with no matching slot writes the lowest-indexed empty slot. The new entry is visible to lookups from the next cycle.
- R7: A fill whose page number and identifier match a valid slot overwrites that slot. No duplicate is created, no other slot is evicted, and at most one slot ever hits.
- R8: When every slot is valid and the fill matches no slot, the victim is the slot under a round-robin pointer. The pointer starts at 0 after reset, advances by one on each such eviction and wraps after the last slot. It moves at no other time.
- R9: flush_all clears every slot at the next clock edge.
- R10: flush_pid_en clears exactly those slots whose stored identifier equals flush_pid. All other slots stay intact.
- R11: A fill presented in the same cycle as either flush is dropped.
- R12: The state field is 5 bits: [1:0] access permission, [2] referenced, [3] modified, [4] cacheable. A fill stores it, and a hit returns it exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_en | input | 1 | Use process identifiers when matching |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Current process identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 32 | Translated physical address (zero on miss) |
| lk_flags | output | 5 | State bits of the hit entry (zero on miss) |
| fill_en | input | 1 | Install an entry this cycle |
| fill_vpn | input | 20 | Page number to install |
| fill_pid | input | 8 | Owner identifier to install |
| fill_frame | input | 20 | Frame number to install |
| fill_flags | input | 5 | State bits to install |
| flush_all | input | 1 | Clear every slot |
| flush_pid_en | input | 1 | Clear the slots owned by flush_pid |
| flush_pid | input | 8 | Identifier to clear |

## Verification
The lookup outputs are combinational, so the bench applies a lookup and samples it a short delay later within the same low clock phase, with no clock edge in between. Fills and flushes change state only at the next rising edge. The bench holds each of them for exactly one edge and looks up no earlier than the following falling edge. Eviction order is measured by filling every slot and then issuing extra fills. After each extra fill, the bench checks which older page now misses and which pages still hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   // state bits carried by every cached translation
   typedef struct packed {
      logic       cache;   // [4]
      logic       dirty;   // [3]
      logic       refd;    // [2]
      logic [1:0] perm;    // [1:0]
   } pte_flags_t;

   localparam int FLAG_W = $bits(pte_flags_t);

   function automatic pte_flags_t flags_none();
      return '0;
   endfunction
endpackage

// File: rtl/tlb_match.sv
// Parallel compare of a key against every slot tag.
module tlb_match #(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input  logic [N-1:0]            valid,
   input  logic [N-1:0][VPN_W-1:0] slot_vpn,
   input  logic [N-1:0][PID_W-1:0] slot_pid,
   input  logic [VPN_W-1:0]        key_vpn,
   input  logic [PID_W-1:0]        key_pid,
   input  logic                    use_pid,
   output logic [N-1:0]            match
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      logic vpn_eq;
      logic pid_eq;
      assign vpn_eq   = (slot_vpn[i] == key_vpn);
      assign pid_eq   = !use_pid || (slot_pid[i] == key_pid);
      assign match[i] = valid[i] && vpn_eq && pid_eq;
   end
endmodule

// File: rtl/tlb_alloc.sv
// Chooses the slot for a fill: duplicate, else lowest free, else round-robin.
module tlb_alloc #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [N-1:0]     valid,
   input  logic [N-1:0]     dup,
   output logic [IDX_W-1:0] slot,
   output logic [IDX_W-1:0] rr_ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   logic [IDX_W-1:0] dup_idx;
   logic [IDX_W-1:0] free_idx;
   logic             any_dup;
   logic             any_free;
   logic             evict;

   always_comb begin
      dup_idx  = '0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (dup[i])    dup_idx  = IDX_W'(i);
         if (!valid[i]) free_idx = IDX_W'(i);
      end
   end

   assign any_dup  = |dup;
   assign any_free = !(&valid);
   assign evict    = req && !any_dup && !any_free;

   always_comb begin
      if (any_dup)       slot = dup_idx;
      else if (any_free) slot = free_idx;
      else               slot = rr_ptr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rr_ptr <= '0;
      else if (evict) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
   end
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = 20,
   parameter int PID_W   = 8,
   localparam int VPN_W  = VA_W - OFF_W,
   localparam int PA_W   = FRAME_W + OFF_W,
   localparam int FLAG_W = tlb_pkg::FLAG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tag_en,
   input  logic [VA_W-1:0]    lk_vaddr,
   input  logic [PID_W-1:0]   lk_pid,
   output logic               lk_hit,
   output logic [PA_W-1:0]    lk_paddr,
   output logic [FLAG_W-1:0]  lk_flags,
   input  logic               fill_en,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [PID_W-1:0]   fill_pid,
   input  logic [FRAME_W-1:0] fill_frame,
   input  logic [FLAG_W-1:0]  fill_flags,
   input  logic               flush_all,
   input  logic               flush_pid_en,
   input  logic [PID_W-1:0]   flush_pid
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("tlb_tagged: ENTRIES must lie in 2..64");
   end
   if (OFF_W < 1 || OFF_W >= VA_W) begin : g_bad_offset
      $error("tlb_tagged: OFF_W must be below VA_W");
   end

   logic [ENTRIES-1:0]              valid_vec;
   logic [ENTRIES-1:0][VPN_W-1:0]   e_vpn;
   logic [ENTRIES-1:0][PID_W-1:0]   e_pid;
   logic [ENTRIES-1:0][FRAME_W-1:0] e_frame;
   logic [ENTRIES-1:0][FLAG_W-1:0]  e_flags;

   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] dup_vec;
   logic [IDX_W-1:0]   fill_slot;
   logic [IDX_W-1:0]   rr_ptr;
   logic               fill_ok;

   assign fill_ok = fill_en && !flush_all && !flush_pid_en;

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_look (
      .valid(valid_vec), .slot_vpn(e_vpn), .slot_pid(e_pid),
      .key_vpn(lk_vaddr[VA_W-1:OFF_W]), .key_pid(lk_pid),
      .use_pid(tag_en), .match(hit_vec)
   );

   tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_dup (
      .valid(valid_vec), .slot_vpn(e_vpn), .slot_pid(e_pid),
      .key_vpn(fill_vpn), .key_pid(fill_pid),
      .use_pid(tag_en), .match(dup_vec)
   );

   tlb_alloc #(.N(ENTRIES)) u_alloc (
      .clk(clk), .rst_n(rst_n), .req(fill_ok),
      .valid(valid_vec), .dup(dup_vec),
      .slot(fill_slot), .rr_ptr(rr_ptr)
   );

   // one-hot read mux
   always_comb begin
      logic [FRAME_W-1:0] frm;
      logic [FLAG_W-1:0]  flg;
      frm = '0;
      flg = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         frm |= e_frame[i] & {FRAME_W{hit_vec[i]}};
         flg |= e_flags[i] & {FLAG_W{hit_vec[i]}};
      end
      lk_hit   = |hit_vec;
      lk_flags = flg;
      lk_paddr = lk_hit ? {frm, lk_vaddr[OFF_W-1:0]} : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_vec <= '0;
      end else if (flush_all) begin
         valid_vec <= '0;
      end else if (flush_pid_en) begin
         for (int i = 0; i < ENTRIES; i++)
            if (e_pid[i] == flush_pid) valid_vec[i] <= 1'b0;
      end else if (fill_ok) begin
         valid_vec[fill_slot] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_ok) begin
         e_vpn[fill_slot]   <= fill_vpn;
         e_pid[fill_slot]   <= fill_pid;
         e_frame[fill_slot] <= fill_frame;
         e_flags[fill_slot] <= fill_flags;
      end
   end
endmodule

// File: rtl/tlb_tagged_chk.sv
module tlb_tagged_chk #(
   parameter int ENTRIES = 8,
   parameter int VA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int PA_W    = 32,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] hit_vec,
   input logic [IDX_W-1:0]   rr_ptr,
   input logic               fill_en,
   input logic               flush_all,
   input logic               flush_pid_en,
   input logic               lk_hit,
   input logic [VA_W-1:0]    lk_vaddr,
   input logic [PA_W-1:0]    lk_paddr
);
   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

   a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_paddr == '0);

   a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> valid_vec == '0);

   a_r6_fill_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush_all && !flush_pid_en) |=> valid_vec != '0);

   a_r8_rr_moves_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rr_ptr) |-> &$past(valid_vec));
endmodule

bind tlb_tagged tlb_tagged_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .hit_vec(hit_vec),
   .rr_ptr(rr_ptr), .fill_en(fill_en), .flush_all(flush_all),
   .flush_pid_en(flush_pid_en), .lk_hit(lk_hit), .lk_vaddr(lk_vaddr),
   .lk_paddr(lk_paddr)
);

// File: tb/tb_tlb_tagged.sv
module tb_tlb_tagged;
   localparam int CLK_PERIOD = 10;
   localparam logic [11:0] OFS = 12'hABC;

   typedef struct packed {
      logic        is_fill;
      logic [19:0] vpn;
      logic [7:0]  pid;
      logic [19:0] frame;   // fill frame or expected frame
      logic [4:0]  flags;   // fill flags or expected flags
      logic        hit;     // expected hit (lookups)
   } vec_t;

   localparam vec_t TBL [12] = '{
      '{1'b1, 20'h00010, 8'h01, 20'h0A000, 5'b00011, 1'b0},
      '{1'b0, 20'h00010, 8'h01, 20'h0A000, 5'b00011, 1'b1},
      '{1'b0, 20'h00010, 8'h02, 20'h00000, 5'b00000, 1'b0},
      '{1'b1, 20'h00010, 8'h02, 20'h0B000, 5'b10101, 1'b0},
      '{1'b0, 20'h00010, 8'h02, 20'h0B000, 5'b10101, 1'b1},
      '{1'b0, 20'h00010, 8'h01, 20'h0A000, 5'b00011, 1'b1},
      '{1'b0, 20'h00011, 8'h01, 20'h00000, 5'b00000, 1'b0},
      '{1'b1, 20'h00010, 8'h01, 20'h0C000, 5'b01001, 1'b0},
      '{1'b0, 20'h00010, 8'h01, 20'h0C000, 5'b01001, 1'b1},
      '{1'b1, 20'hFFFFF, 8'hFF, 20'hFFFFF, 5'b11111, 1'b0},
      '{1'b0, 20'hFFFFF, 8'hFF, 20'hFFFFF, 5'b11111, 1'b1},
      '{1'b0, 20'hFFFFF, 8'hFE, 20'h00000, 5'b00000, 1'b0}
   };

   logic        clk = 0, rst_n = 0, tag_en = 1;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_pid = '0;
   logic        lk_hit;
   logic [31:0] lk_paddr;
   logic [4:0]  lk_flags;
   logic        fill_en = 0;
   logic [19:0] fill_vpn = '0;
   logic [7:0]  fill_pid = '0;
   logic [19:0] fill_frame = '0;
   logic [4:0]  fill_flags = '0;
   logic        flush_all = 0, flush_pid_en = 0;
   logic [7:0]  flush_pid = '0;

   int n_vec = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_tagged dut (
      .clk(clk), .rst_n(rst_n), .tag_en(tag_en),
      .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
      .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_flags(lk_flags),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
      .fill_frame(fill_frame), .fill_flags(fill_flags),
      .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
   );

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // lookup, sampled in the same low phase
   task automatic look(string req, logic [19:0] vpn, logic [7:0] pid,
                       logic exp_hit, logic [19:0] exp_frame, logic [4:0] exp_flags);
      logic [31:0] exp_pa;
      @(negedge clk);
      lk_vaddr = {vpn, OFS};
      lk_pid   = pid;
      #1;
      exp_pa = exp_hit ? {exp_frame, OFS} : 32'h0;
      if (!exp_hit) exp_flags = '0;
      n_vec++;
      if (lk_hit !== exp_hit || lk_paddr !== exp_pa || lk_flags !== exp_flags) begin
         n_bad++;
         $display("FAIL %s: vpn=%h pid=%h got hit=%b pa=%h fl=%b, want hit=%b pa=%h fl=%b",
                  req, vpn, pid, lk_hit, lk_paddr, lk_flags, exp_hit, exp_pa, exp_flags);
      end
   endtask

   task automatic fill(logic [19:0] vpn, logic [7:0] pid, logic [19:0] frame,
                       logic [4:0] flags);
      @(negedge clk);
      fill_en = 1; fill_vpn = vpn; fill_pid = pid;
      fill_frame = frame; fill_flags = flags;
      @(negedge clk);
      fill_en = 0;
   endtask

   task automatic flush(logic all, logic by_pid, logic [7:0] pid);
      @(negedge clk);
      flush_all = all; flush_pid_en = by_pid; flush_pid = pid;
      @(negedge clk);
      flush_all = 0; flush_pid_en = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: empty after reset
      look("R1", 20'h00010, 8'h01, 0, 0, 0);
      look("R1", 20'h00000, 8'h00, 0, 0, 0);
      rst_n = 1;
      look("R1", 20'h00010, 8'h01, 0, 0, 0);

      // table walk: R2 R3 R4 R7 R12
      foreach (TBL[k]) begin
         if (TBL[k].is_fill)
            fill(TBL[k].vpn, TBL[k].pid, TBL[k].frame, TBL[k].flags);
         else
            look(k == 2 || k == 6 || k == 11 ? "R3" : "R2/R4/R7/R12",
                 TBL[k].vpn, TBL[k].pid, TBL[k].hit, TBL[k].frame, TBL[k].flags);
      end

      // R9: global clear
      flush(1, 0, 0);
      look("R9", 20'h00010, 8'h01, 0, 0, 0);
      look("R9", 20'h00010, 8'h02, 0, 0, 0);
      look("R9", 20'hFFFFF, 8'hFF, 0, 0, 0);

      // R6: fill all eight slots
      for (int i = 0; i < 8; i++)
         fill(20'h00100 + 20'(i), 8'h03, 20'h10000 + 20'(i), 5'b00001);
      for (int i = 0; i < 8; i++)
         look("R6", 20'h00100 + 20'(i), 8'h03, 1, 20'h10000 + 20'(i), 5'b00001);

      // R7: duplicate while full overwrites, no eviction
      fill(20'h00103, 8'h03, 20'h2AAAA, 5'b00110);
      look("R7", 20'h00103, 8'h03, 1, 20'h2AAAA, 5'b00110);
      for (int i = 0; i < 8; i++)
         if (i != 3) look("R7", 20'h00100 + 20'(i), 8'h03, 1, 20'h10000 + 20'(i), 5'b00001);

      // R8: round-robin victims slot 0 then slot 1
      fill(20'h00200, 8'h03, 20'h30000, 5'b00010);
      look("R8", 20'h00100, 8'h03, 0, 0, 0);
      look("R8", 20'h00101, 8'h03, 1, 20'h10001, 5'b00001);
      look("R8", 20'h00200, 8'h03, 1, 20'h30000, 5'b00010);
      fill(20'h00201, 8'h03, 20'h30001, 5'b00010);
      look("R8", 20'h00101, 8'h03, 0, 0, 0);
      look("R8", 20'h00102, 8'h03, 1, 20'h10002, 5'b00001);

      // R10: per-process clear
      flush(1, 0, 0);
      fill(20'h00300, 8'h04, 20'h40000, 5'b00001);
      fill(20'h00301, 8'h05, 20'h40001, 5'b00001);
      fill(20'h00302, 8'h04, 20'h40002, 5'b00001);
      flush(0, 1, 8'h04);
      look("R10", 20'h00300, 8'h04, 0, 0, 0);
      look("R10", 20'h00301, 8'h05, 1, 20'h40001, 5'b00001);
      look("R10", 20'h00302, 8'h04, 0, 0, 0);

      // R11: fill dropped when a flush is present
      @(negedge clk);
      fill_en = 1; fill_vpn = 20'h00400; fill_pid = 8'h05;
      fill_frame = 20'h50000; fill_flags = 5'b00001;
      flush_pid_en = 1; flush_pid = 8'h09;
      @(negedge clk);
      fill_en = 0; flush_pid_en = 0;
      look("R11", 20'h00400, 8'h05, 0, 0, 0);
      look("R11", 20'h00301, 8'h05, 1, 20'h40001, 5'b00001);

      // R5: tagging off
      tag_en = 0;
      fill(20'h00500, 8'h01, 20'h60000, 5'b00001);
      look("R5", 20'h00500, 8'h07, 1, 20'h60000, 5'b00001);
      fill(20'h00500, 8'h02, 20'h60001, 5'b01000);
      look("R5", 20'h00500, 8'h01, 1, 20'h60001, 5'b01000);

      report();
   end
endmodule